// File: doc/BRIEF.md
# Programmable-Resolution Tracking Angle Counter

This block holds the digital shaft angle inside a type-II tracking resolver-to-digital loop. The loop's rate generator is modelled as a pulse source. Each single-cycle pulse on the up or down input moves the held angle by one count of the active resolution. The result is always presented as a 16-bit natural-binary word, MSB-justified: bit 15 weighs 180 degrees, and the bits below the active resolution read as zero.

A 2-bit select picks a resolution of 10, 12, 14 or 16 bits. The select may change at any time while the loop is tracking. It is copied into an internal register only on a clock edge that carries no count pulse, so a change of resolution can never collide with an update of the angle. When the resolution becomes coarser, the angle bits below the new LSB are cleared in that same edge. The pulse inputs and the select are plain control pins with no handshake. The angle output is a plain registered word with no valid/ready: every edge produces a new value, and the block never stalls, so there is no back-pressure.

Top module: `angle_track_counter`

## Requirements
- R1: A synchronous reset, active high, clears the angle to 0 and makes 16-bit mode active. The angle reads 0 after the edge that samples the reset.
- R2: The select encoding is 2'b00 for 10-bit, 2'b01 for 12-bit, 2'b10 for 14-bit and 2'b11 for 16-bit. An up pulse alone adds the active LSB weight, 2^(16-N): 64, 16, 4 or 1 respectively.
- R3: A down pulse alone subtracts the active LSB weight.
- R4: The angle wraps modulo 2^16 in both directions.
- R5: When up and down are asserted in the same cycle, they cancel. The angle holds, and that edge also counts as carrying a pulse for R6.
- R6: The select is copied only on an edge where neither pulse is asserted. On an edge that carries a pulse, the step uses the previously active resolution.
- R7: On an edge where the select is copied, the angle is ANDed with the keep-mask of the new resolution. A coarser mode clears the bits below its LSB; a finer mode leaves the angle unchanged.
- R8: The angle bits below the active LSB are always zero.
- R9: An input sampled on a rising edge is reflected on the angle output directly after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| res_sel | input | 2 | Requested resolution (00=10b, 01=12b, 10=14b, 11=16b) |
| up_pulse | input | 1 | Count-up pulse, one count per cycle high |
| dn_pulse | input | 1 | Count-down pulse, one count per cycle high |
| angle | output | 16 | Natural-binary angle, MSB-justified, bit 15 = 180 degrees |

## Verification
Every result is due one edge after its stimulus: a pulse, a cancelled pulse pair, a resolution switch or a reset is visible on the angle as soon as the edge that samples it has passed. The driver applies one stimulus per cycle at the falling edge and pushes the value the requirement predicts. The monitor pops that value shortly after the following rising edge and compares it, so every check lands exactly one register stage after its input. Switches of the select in a cycle that carries a pulse are followed by idle cycles, so both the deferred step and the later clearing are checked at their own edges.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int ANGLE_W    = 16;
  localparam int SEL_W      = 2;
  localparam int MODES      = 1 << SEL_W;
  localparam int FIELD_STEP = 2;

  // LSB weight of the mode in 16-bit units: 2^(FIELD_STEP*(MODES-1-mode))
  function automatic logic [ANGLE_W-1:0] lsb_weight(input int mode);
    return ANGLE_W'(1) << (FIELD_STEP * (MODES - 1 - mode));
  endfunction

  function automatic logic [ANGLE_W-1:0] keep_mask(input int mode);
    return ~(lsb_weight(mode) - ANGLE_W'(1));
  endfunction
endpackage

// File: rtl/atc_res_latch.sv
module atc_res_latch #(
  parameter int SEL_W = atc_pkg::SEL_W,
  parameter logic [SEL_W-1:0] RESET_SEL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_evt,
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst)             sel_q <= RESET_SEL;
    else if (!count_evt) sel_q <= sel_in;
  end

  // R6: the active resolution never moves on an edge that carries a pulse
  assert_res_hold_R6: assert property (@(posedge clk) disable iff (rst)
    count_evt |=> $stable(sel_q));

  // R6: on an idle edge the request is taken
  assert_res_take_R6: assert property (@(posedge clk) disable iff (rst)
    !count_evt |=> sel_q == $past(sel_in));
endmodule

// File: rtl/atc_step_gen.sv
module atc_step_gen #(
  parameter int ANGLE_W = atc_pkg::ANGLE_W,
  parameter int SEL_W   = atc_pkg::SEL_W,
  localparam int MODES  = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]   sel,
  output logic [ANGLE_W-1:0] step,
  output logic [ANGLE_W-1:0] mask
);
  logic [ANGLE_W-1:0] weight_tbl [MODES];
  logic [ANGLE_W-1:0] mask_tbl   [MODES];

  for (genvar g = 0; g < MODES; g++) begin : g_mode
    assign weight_tbl[g] = atc_pkg::lsb_weight(g);
    assign mask_tbl[g]   = atc_pkg::keep_mask(g);
  end

  assign step = weight_tbl[sel];
  assign mask = mask_tbl[sel];

  always_comb begin
    assert_step_onehot_R2: assert ($countones(step) == 1);
  end
endmodule

// File: rtl/atc_accum.sv
module atc_accum #(
  parameter int ANGLE_W = atc_pkg::ANGLE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up,
  input  logic               dn,
  input  logic [ANGLE_W-1:0] step,
  input  logic [ANGLE_W-1:0] new_mask,
  output logic [ANGLE_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)              acc <= '0;
    else if (up && !dn)   acc <= acc + step;
    else if (dn && !up)   acc <= acc - step;
    else if (!up && !dn)  acc <= acc & new_mask;
  end

  // R1: reset clears the angle
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> acc == '0);

  // R2 / R4: up adds the active weight, modulo 2^ANGLE_W
  assert_up_step_R2: assert property (@(posedge clk) disable iff (rst)
    (up && !dn) |=> acc == ANGLE_W'($past(acc) + $past(step)));

  // R3 / R4: down subtracts the active weight, modulo 2^ANGLE_W
  assert_dn_step_R3: assert property (@(posedge clk) disable iff (rst)
    (dn && !up) |=> acc == ANGLE_W'($past(acc) - $past(step)));

  // R5: simultaneous pulses cancel
  assert_cancel_R5: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> $stable(acc));
endmodule

// File: rtl/angle_track_counter.sv
module angle_track_counter #(
  parameter int ANGLE_W = atc_pkg::ANGLE_W,
  parameter int SEL_W   = atc_pkg::SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   res_sel,
  input  logic               up_pulse,
  input  logic               dn_pulse,
  output logic [ANGLE_W-1:0] angle
);
  logic [SEL_W-1:0]   active_sel;
  logic [ANGLE_W-1:0] active_step;
  logic [ANGLE_W-1:0] active_mask;
  logic [ANGLE_W-1:0] req_step;
  logic [ANGLE_W-1:0] req_mask;
  logic               count_evt;

  assign count_evt = up_pulse | dn_pulse;

  atc_res_latch #(.SEL_W(SEL_W)) u_res (
    .clk(clk), .rst(rst), .count_evt(count_evt),
    .sel_in(res_sel), .sel_q(active_sel)
  );

  atc_step_gen #(.ANGLE_W(ANGLE_W), .SEL_W(SEL_W)) u_step_act (
    .sel(active_sel), .step(active_step), .mask(active_mask)
  );

  atc_step_gen #(.ANGLE_W(ANGLE_W), .SEL_W(SEL_W)) u_step_req (
    .sel(res_sel), .step(req_step), .mask(req_mask)
  );

  atc_accum #(.ANGLE_W(ANGLE_W)) u_acc (
    .clk(clk), .rst(rst), .up(up_pulse), .dn(dn_pulse),
    .step(active_step), .new_mask(req_mask), .acc(angle)
  );

  // R8: nothing below the active LSB is ever set
  assert_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (angle & ~active_mask) == '0);

  // R7: an idle edge leaves the angle inside the new keep-mask
  assert_switch_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !count_evt |=> angle == ($past(angle) & $past(req_mask)));

  logic unused_req_step;
  assign unused_req_step = ^req_step;
endmodule

// File: tb/angle_track_counter_tb.sv
module angle_track_counter_tb;
  logic        clk = 0;
  logic        rst = 0;
  logic [1:0]  res_sel = 2'b11;
  logic        up_pulse = 0;
  logic        dn_pulse = 0;
  logic [15:0] angle;

  int total = 0;
  int bad = 0;
  int m_ang = 0;
  int m_res = 3;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  angle_track_counter u_dut (
    .clk(clk), .rst(rst), .res_sel(res_sel),
    .up_pulse(up_pulse), .dn_pulse(dn_pulse), .angle(angle)
  );

  // driver: one stimulus per cycle, expected value from the requirements
  task automatic apply(input logic r, input logic u, input logic d,
                       input logic [1:0] s, input string tag);
    int stp;
    @(negedge clk);
    rst = r; up_pulse = u; dn_pulse = d; res_sel = s;
    if (r) begin
      m_ang = 0; m_res = 3;
    end else if (u || d) begin
      stp = 1 << (6 - 2*m_res);
      if (u && !d) m_ang = (m_ang + stp) & 16'hFFFF;
      else if (d && !u) m_ang = (m_ang - stp) & 16'hFFFF;
    end else begin
      m_res = int'(s);
      stp = 1 << (6 - 2*m_res);
      m_ang = m_ang & ~(stp - 1) & 16'hFFFF;
    end
    exp_q.push_back(m_ang);
    tag_q.push_back(tag);
  endtask

  // monitor: compares just after the edge that sampled the stimulus (R9)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (int'(angle) != e) begin
          bad++;
          $display("FAIL %s actual=%0d expected=%0d", t, angle, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    apply(1, 0, 0, 2'b11, "R1 reset");
    apply(1, 1, 0, 2'b11, "R1 reset holds over pulse");
    apply(0, 0, 0, 2'b11, "R7 select 16-bit");
    apply(0, 1, 0, 2'b11, "R2 up 16-bit");
    apply(0, 1, 0, 2'b11, "R2 up 16-bit");
    apply(0, 1, 0, 2'b11, "R9 up 16-bit next edge");
    apply(0, 0, 1, 2'b11, "R3 down 16-bit");
    apply(0, 0, 0, 2'b00, "R7 coarser clears low bits");
    apply(0, 1, 0, 2'b00, "R2 up 10-bit");
    apply(0, 1, 0, 2'b00, "R2 up 10-bit");
    apply(0, 1, 0, 2'b01, "R6 select change during pulse");
    apply(0, 0, 0, 2'b01, "R7 finer keeps angle");
    apply(0, 1, 0, 2'b01, "R2 up 12-bit");
    apply(0, 1, 1, 2'b01, "R5 pulses cancel");
    apply(0, 1, 1, 2'b10, "R5 cancel defers select");
    apply(0, 0, 0, 2'b10, "R7 select 14-bit");
    apply(0, 0, 1, 2'b10, "R3 down 14-bit");
    apply(0, 1, 0, 2'b10, "R2 up 14-bit");
    apply(1, 0, 0, 2'b00, "R1 reset mid-run");
    apply(0, 0, 0, 2'b00, "R7 select 10-bit");
    apply(0, 0, 1, 2'b00, "R4 wrap down 10-bit");
    apply(0, 1, 0, 2'b00, "R4 wrap up 10-bit");
    apply(0, 0, 0, 2'b11, "R7 select 16-bit");
    apply(0, 0, 1, 2'b11, "R4 wrap down 16-bit");
    apply(0, 0, 0, 2'b00, "R8 coarse clears 6 low bits");
    apply(0, 0, 1, 2'b10, "R6 down uses old 10-bit step");
    apply(0, 0, 0, 2'b10, "R8 14-bit keeps angle");
    apply(0, 0, 1, 2'b10, "R3 down 14-bit");
    apply(0, 0, 0, 2'b10, "R9 idle holds");
    @(negedge clk);
    rst = 0; up_pulse = 0; dn_pulse = 0;
    repeat (3) @(posedge clk);
    #3;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R9 pending actual=%0d expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule